// File: doc/BRIEF.md
# Programmable Flat-Panel Timing Generator

This block produces the raster timing for a flat panel: a pixel-clock enable strobe, an inverted-or-not pixel clock level, horizontal and vertical sync, data enable, a start-of-frame pulse and the pixel coordinate inside the active area. A host supplies the geometry as two packed timing words (one per axis) plus a pixel clock divide value and four polarity bits. Every interval field holds its length minus one. The divide value is taken as is.

Each axis runs through four phases in a fixed order: sync, back porch, active, front porch. The horizontal axis counts pixel-clock strobes. The vertical axis counts completed lines. The block runs only while `enable` is high. All configuration is captured when a frame starts, so a host may rewrite the inputs at any time without tearing the current frame. The active area is limited to `MAX_W` by `MAX_H` (800 by 600 by default).

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset with `enable` low and `pol_inv` zero, `pix_ce`, `pclk_o`, `hsync_o`, `vsync_o`, `de_o` and `sof_o` are 0, and `x_o` and `y_o` are 0.
- R2: While running, `pix_ce` pulses for one clock every `clk_div`+1 clocks. The first pulse comes `clk_div`+1 clocks after the cycle in which `enable` is sampled high.
- R3: Horizontal timing word layout: sync width in bits 15:10, back porch in 23:16, active pixels in 9:0, front porch in 31:24. Each field is a length minus one. A line is that many strobes in the order sync, back porch, active, front porch. `hsync_o` is asserted during the sync phase.
- R4: The vertical word uses the same bit layout, measured in lines. The line count advances once per completed horizontal period. `vsync_o` is asserted during the vertical sync lines.
- R5: `de_o` is asserted only when both axes are in their active phase. `x_o` and `y_o` count from 0 at the first active pixel and line, and read 0 outside the active area.
- R6: `sof_o` is high for exactly one clock: the cycle carrying the first `pix_ce` strobe of each frame, when vertical sync begins.
- R7: `pol_inv` bit 3 inverts `de_o`, bit 2 inverts `pclk_o`, bit 1 inverts `hsync_o` and bit 0 inverts `vsync_o`. `pclk_o` is `pix_ce` before inversion.
- R8: An active field above the limit is clamped to `MAX_W` pixels or `MAX_H` lines.
- R9: Dropping `enable` puts every output at its inactive level in the same cycle. Raising it again starts a new frame at the first sync strobe.
- R10: `h_cfg`, `v_cfg`, `clk_div` and `pol_inv` are captured only at frame start. A change made mid-frame takes effect at the next frame.
- R11: All-zero timing fields give a single strobe per phase, which is a 4-strobe line and a 4-line frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global run enable |
| h_cfg | input | 32 | Packed horizontal timing word |
| v_cfg | input | 32 | Packed vertical timing word |
| clk_div | input | 10 | Pixel clock divide value |
| pol_inv | input | 4 | Inversion bits {de, pclk, hsync, vsync} |
| pix_ce | output | 1 | Pixel clock enable strobe |
| pclk_o | output | 1 | Pixel clock level after inversion |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| sof_o | output | 1 | Start-of-frame pulse |
| x_o | output | 10 | Active-area pixel column |
| y_o | output | 10 | Active-area line |

## Verification
The hardest case to reach is a host write that lands mid-frame. The old geometry must survive to the frame boundary and the new one must take over exactly at the wrap. The stimulus rewrites `h_cfg` right after the fifth strobe of a running frame. It then walks the rest of that frame with the old expected geometry and the following frame with the new one, with no restart in between. The active-area clamp is reached with one axis kept minimal, so that a full frame stays a few thousand strobes long.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int MAX_W = 800,
  parameter int MAX_H = 600,
  parameter int CW    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] h_cfg,
  input  logic [31:0] v_cfg,
  input  logic [9:0]  clk_div,
  input  logic [3:0]  pol_inv,
  output logic        pix_ce,
  output logic        pclk_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o,
  output logic        sof_o,
  output logic [9:0]  x_o,
  output logic [9:0]  y_o
);

  function automatic logic [CW-1:0] act_len(input logic [9:0] f, input int lim);
    logic [CW-1:0] n;
    n = CW'(f) + CW'(1);
    return (n > CW'(lim)) ? CW'(lim) : n;
  endfunction

  logic          run;
  logic [31:0]   hq, vq;
  logic [9:0]    div_q, dcnt;
  logic [3:0]    inv_q;
  logic [CW-1:0] hpos, vpos;

  logic [CW-1:0] h_se, h_ab, h_ae, h_tot;
  logic [CW-1:0] v_se, v_ab, v_ae, v_tot;

  assign h_se  = CW'(hq[15:10]) + CW'(1);
  assign h_ab  = h_se + CW'(hq[23:16]) + CW'(1);
  assign h_ae  = h_ab + act_len(hq[9:0], MAX_W);
  assign h_tot = h_ae + CW'(hq[31:24]) + CW'(1);

  assign v_se  = CW'(vq[15:10]) + CW'(1);
  assign v_ab  = v_se + CW'(vq[23:16]) + CW'(1);
  assign v_ae  = v_ab + act_len(vq[9:0], MAX_H);
  assign v_tot = v_ae + CW'(vq[31:24]) + CW'(1);

  logic active, strobe, h_last, v_last, wrap;
  assign active = run & enable;
  assign strobe = active & (dcnt == div_q);
  assign h_last = (hpos == h_tot - CW'(1));
  assign v_last = (vpos == v_tot - CW'(1));
  assign wrap   = strobe & h_last & v_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      hq    <= '0;
      vq    <= '0;
      div_q <= '0;
      inv_q <= '0;
      dcnt  <= '0;
      hpos  <= '0;
      vpos  <= '0;
    end else if (!enable) begin
      run <= 1'b0;
    end else if (!run || wrap) begin
      run   <= 1'b1;
      hq    <= h_cfg;
      vq    <= v_cfg;
      div_q <= clk_div;
      inv_q <= pol_inv;
      dcnt  <= '0;
      hpos  <= '0;
      vpos  <= '0;
    end else begin
      dcnt <= strobe ? '0 : dcnt + 10'd1;
      if (strobe) begin
        if (h_last) begin
          hpos <= '0;
          vpos <= vpos + CW'(1);
        end else begin
          hpos <= hpos + CW'(1);
        end
      end
    end
  end

  logic hs_r, vs_r, h_in, v_in, de_r;
  logic [3:0] inv_e;
  assign hs_r  = active & (hpos < h_se);
  assign vs_r  = active & (vpos < v_se);
  assign h_in  = (hpos >= h_ab) && (hpos < h_ae);
  assign v_in  = (vpos >= v_ab) && (vpos < v_ae);
  assign de_r  = active & h_in & v_in;
  assign inv_e = active ? inv_q : pol_inv;

  assign pix_ce  = strobe;
  assign pclk_o  = strobe ^ inv_e[2];
  assign hsync_o = hs_r ^ inv_e[1];
  assign vsync_o = vs_r ^ inv_e[0];
  assign de_o    = de_r ^ inv_e[3];
  assign sof_o   = strobe & (hpos == '0) & (vpos == '0);
  assign x_o     = de_r ? 10'(hpos - h_ab) : 10'd0;
  assign y_o     = de_r ? 10'(vpos - v_ab) : 10'd0;

  a_r2_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && div_q != 10'd0) |=> !strobe);

  a_r3_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de_r |-> !hs_r);

  a_r6_sof_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> (strobe && vs_r && hs_r));

  a_r8_x_bound: assert property (@(posedge clk) disable iff (!rst_n)
    de_r |-> (int'(x_o) < MAX_W && int'(y_o) < MAX_H));

  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && enable && !wrap) |=> ($stable(hq) && $stable(vq) && $stable(div_q)));

endmodule

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
  logic clk = 0, rst_n = 0, enable = 0;
  logic [31:0] h_cfg = 0, v_cfg = 0;
  logic [9:0] clk_div = 0;
  logic [3:0] pol_inv = 0;
  logic pix_ce, pclk_o, hsync_o, vsync_o, de_o, sof_o;
  logic [9:0] x_o, y_o;
  int errors = 0, checks = 0, gap = 0;

  always #5 clk = ~clk;

  lcd_timing_gen u0 (.clk(clk), .rst_n(rst_n), .enable(enable), .h_cfg(h_cfg),
    .v_cfg(v_cfg), .clk_div(clk_div), .pol_inv(pol_inv), .pix_ce(pix_ce),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .sof_o(sof_o), .x_o(x_o), .y_o(y_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int sw, input int bp, input int ac, input int fp);
    return {8'(fp), 8'(bp), 6'(sw), 10'(ac)};
  endfunction

  task automatic geo(input logic [31:0] w, input int lim, output int se, output int ab,
                     output int ae, output int tot);
    int a;
    a = int'(w[9:0]) + 1;
    if (a > lim) a = lim;
    se = int'(w[15:10]) + 1;
    ab = se + int'(w[23:16]) + 1;
    ae = ab + a;
    tot = ae + int'(w[31:24]) + 1;
  endtask

  task automatic start(input logic [31:0] h, input logic [31:0] v, input logic [9:0] d, input logic [3:0] inv);
    @(negedge clk);
    enable = 0;
    repeat (2) @(negedge clk);
    h_cfg = h; v_cfg = v; clk_div = d; pol_inv = inv;
    enable = 1;
    gap = 0;
  endtask

  task automatic walk(input logic [31:0] h, input logic [31:0] v, input logic [9:0] d,
                      input logic [3:0] inv, input int limit, input int chg_at,
                      input logic [31:0] newh, input string req);
    int hse, hab, hae, htot, vse, vab, vae, vtot, tot, n, hh, ll;
    bit de;
    logic [31:0] exp, act;
    geo(h, 800, hse, hab, hae, htot);
    geo(v, 600, vse, vab, vae, vtot);
    tot = htot * vtot;
    if (limit > 0 && limit < tot) tot = limit;
    n = 0;
    while (n < tot) begin
      @(negedge clk);
      gap++;
      if (pix_ce) begin
        chk(gap == int'(d) + 1, {"R2 ", req}, gap, int'(d) + 1);
        hh = n % htot;
        ll = n / htot;
        de = (hh >= hab && hh < hae && ll >= vab && ll < vae);
        exp = {7'd0, (hh < hse) ^ inv[1], (ll < vse) ^ inv[0], de ^ inv[3], 1'b1 ^ inv[2],
               n == 0, de ? 10'(hh - hab) : 10'd0, de ? 10'(ll - vab) : 10'd0};
        act = {7'd0, hsync_o, vsync_o, de_o, pclk_o, sof_o, x_o, y_o};
        chk(act == exp, req, act, exp);
        n++;
        gap = 0;
        if (n == chg_at) h_cfg = newh;
      end else begin
        chk(sof_o == 1'b0 && pclk_o == inv[2], {"R6 R7 ", req}, {sof_o, pclk_o}, {1'b0, inv[2]});
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) begin
      @(negedge clk);
      chk({pix_ce, pclk_o, hsync_o, vsync_o, de_o, sof_o, x_o, y_o} == 0, "R1 reset idle",
          {pix_ce, pclk_o, hsync_o, vsync_o, de_o, sof_o, x_o, y_o}, 0);
    end
  endtask

  task automatic t_basic;
    logic [31:0] h, v;
    h = pack(1, 2, 7, 1);
    v = pack(0, 1, 3, 0);
    start(h, v, 1, 0);
    walk(h, v, 1, 0, 0, -1, 0, "R3 R4 R5 R6 frame0");
    walk(h, v, 1, 0, 0, -1, 0, "R3 R4 R5 R6 frame1");
  endtask

  task automatic t_div;
    logic [31:0] h, v;
    h = pack(0, 1, 4, 2);
    v = pack(1, 0, 2, 1);
    start(h, v, 3, 0);
    walk(h, v, 3, 0, 0, -1, 0, "R2 divide 4");
  endtask

  task automatic t_pol;
    logic [31:0] h, v;
    h = pack(2, 0, 5, 0);
    v = pack(0, 0, 2, 1);
    start(h, v, 0, 4'hF);
    walk(h, v, 0, 4'hF, 0, -1, 0, "R7 all inverted");
    start(h, v, 0, 4'b1010);
    walk(h, v, 0, 4'b1010, 0, -1, 0, "R7 de and hsync inverted");
  endtask

  task automatic t_clamp;
    logic [31:0] h, v;
    h = pack(0, 0, 1000, 0);
    v = pack(0, 0, 0, 0);
    start(h, v, 0, 0);
    walk(h, v, 0, 0, 0, -1, 0, "R8 width clamp");
    h = pack(0, 0, 0, 0);
    v = pack(0, 0, 1020, 0);
    start(h, v, 0, 0);
    walk(h, v, 0, 0, 0, -1, 0, "R8 height clamp");
  endtask

  task automatic t_min;
    logic [31:0] h, v;
    h = 0; v = 0;
    start(h, v, 0, 0);
    walk(h, v, 0, 0, 0, -1, 0, "R11 minimum frame");
  endtask

  task automatic t_midwrite;
    logic [31:0] a, b, v;
    a = pack(1, 1, 5, 1);
    b = pack(0, 2, 3, 0);
    v = pack(0, 0, 2, 0);
    start(a, v, 0, 0);
    walk(a, v, 0, 0, 0, 5, b, "R10 old frame kept");
    walk(b, v, 0, 0, 0, -1, 0, "R10 new frame applied");
  endtask

  task automatic t_disable;
    logic [31:0] h, v;
    logic [3:0] inv;
    h = pack(1, 1, 6, 1);
    v = pack(0, 1, 2, 0);
    inv = 4'b0101;
    start(h, v, 1, inv);
    walk(h, v, 1, inv, 10, -1, 0, "R9 before stop");
    @(negedge clk);
    enable = 0;
    #1;
    chk({pix_ce, pclk_o, hsync_o, vsync_o, de_o, sof_o} == {1'b0, inv[2], inv[1], inv[0], inv[3], 1'b0},
        "R9 stop same cycle", {pix_ce, pclk_o, hsync_o, vsync_o, de_o, sof_o},
        {1'b0, inv[2], inv[1], inv[0], inv[3], 1'b0});
    repeat (4) @(negedge clk);
    chk({pix_ce, pclk_o, hsync_o, vsync_o, de_o, sof_o, x_o, y_o} ==
        {1'b0, inv[2], inv[1], inv[0], inv[3], 1'b0, 20'd0},
        "R9 held inactive", {pix_ce, pclk_o, hsync_o, vsync_o, de_o, sof_o, x_o, y_o},
        {1'b0, inv[2], inv[1], inv[0], inv[3], 1'b0, 20'd0});
    enable = 1;
    gap = 0;
    walk(h, v, 1, inv, 0, -1, 0, "R9 restart from sync");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_div;
    t_pol;
    t_clamp;
    t_min;
    t_midwrite;
    t_disable;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule